// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked host and an external asynchronous static RAM of 128K eight-bit words. The host asks for one word at a time with a request/ready handshake, giving a 17-bit address, a direction flag and, for stores, a data byte. The controller then runs a complete memory cycle on the pins and returns to idle. Loaded bytes come back on a result bus with a one-cycle valid strobe.

Each memory cycle is timed by counters. Their limits are derived from nanosecond minimums and the clock period by ceiling division, so one set of parameters serves every speed grade and clock rate. The memory is selected only while the active-low and the active-high chip enables are both asserted. A store always ends on the rising edge of the write strobe, while the chip stays selected, and the data bus is released one cycle later. A load is followed by a bus-turnaround gap, because the memory may keep driving the bus for a while after output enable is removed. Any store that comes next does not drive the bus until that gap has passed.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no request, ready is 1, rd_valid is 0, mem_ce_n is 1, mem_ce2 is 0, mem_oe_n is 1, mem_we_n is 1 and mem_dq_oe is 0.
- R2: mem_we_n or mem_oe_n is low only while the memory is selected, meaning mem_ce_n is 0 and mem_ce2 is 1.
- R3: mem_dq_oe is never 1 in a cycle where mem_oe_n is 0, so the two sides never drive the data bus at once.
- R4: After a load is accepted, mem_oe_n stays low for exactly RD_CYC cycles with the memory selected. The controller captures mem_dq_in on the last of those edges. rd_data is presented with rd_valid high for exactly one cycle, RD_CYC cycles after acceptance.
- R5: A store holds mem_we_n low for exactly WR_CYC consecutive cycles. Throughout that pulse, mem_dq_oe is 1 and mem_dq_out carries the accepted byte.
- R6: A store ends with mem_we_n rising while the memory is still selected and mem_dq_oe is still 1. mem_dq_oe falls only after mem_we_n has been high for at least one cycle.
- R7: While the memory stays selected, mem_addr does not change and equals the address accepted for that cycle, including the boundary addresses 0 and 0x1FFFF.
- R8: After mem_oe_n rises at the end of a load, mem_dq_oe does not rise until at least TURN_CYC clock edges later.
- R9: ready falls on the edge that accepts a request and stays low until the cycle completes. Requests presented while ready is low are ignored and change no memory word.
- R10: RD_CYC, WR_CYC and TURN_CYC are each the ceiling of the corresponding nanosecond limit divided by the clock period, and never less than 1. The defaults of 55 ns, 55 ns and 30 ns at a 4 ns clock give 14, 14 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Host request, taken when ready is 1 |
| req_write | input | 1 | 1 selects a store, 0 a load |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Byte to store |
| ready | output | 1 | Controller idle and able to accept |
| rd_data | output | DATA_W | Byte returned by a load |
| rd_valid | output | 1 | One-cycle strobe qualifying rd_data |
| mem_addr | output | ADDR_W | Address pins of the memory |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_in | input | DATA_W | Data received from the memory |
| mem_dq_oe | output | 1 | Drive enable for the bidirectional data pins |

## Verification
The assertions assume that the host changes req, req_write, req_addr and req_wdata only away from the clock edge. They also assume that mem_dq_in carries the addressed word whenever the memory is selected with output enable low and the write strobe high. The bench drives the host inputs on the falling edge. Its memory model refreshes mem_dq_in at the same time, so the word is settled well before the capturing edge. Random traffic keeps most addresses in a small pool so that loads hit earlier stores. Directed steps add the boundary addresses, a store straight after a load, and requests issued while the controller is busy.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD     = 3'd1,
    ST_WGAP   = 3'd2,
    ST_WPULSE = 3'd3,
    ST_WEND   = 3'd4
  } seq_state_e;

  // Ceiling of a nanosecond limit over the clock period, at least one cycle.
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned clk_ps);
    int unsigned c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  // Bits needed to hold values 0..n.
  function automatic int unsigned count_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_interval_timer.sv
module sram_interval_timer #(
  parameter int unsigned W      = 4,
  parameter int unsigned THRESH = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         hit
);

  logic [W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              count_q <= '0;
    else if (load)           count_q <= load_val;
    else if (count_q != '0)  count_q <= count_q - 1'b1;
  end

  assign hit = (count_q <= W'(THRESH));

endmodule

// File: rtl/sram_cycle_fsm.sv
module sram_cycle_fsm
  import sram_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       req_write,
  input  logic       phase_hit,
  input  logic       gap_clear,
  output seq_state_e state_q,
  output seq_state_e state_d,
  output logic       accept,
  output logic       rd_done,
  output logic       pulse_start
);

  assign accept = (state_q == ST_IDLE) && req;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept)
        state_d = !req_write ? ST_RD : (gap_clear ? ST_WPULSE : ST_WGAP);
      ST_RD:     if (phase_hit) state_d = ST_IDLE;
      ST_WGAP:   if (gap_clear) state_d = ST_WPULSE;
      ST_WPULSE: if (phase_hit) state_d = ST_WEND;
      ST_WEND:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign rd_done     = (state_q == ST_RD) && phase_hit;
  assign pulse_start = (state_d == ST_WPULSE) && (state_q != ST_WPULSE);

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 17,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CLK_PS     = 4000,
  parameter int unsigned T_RD_NS    = 55,
  parameter int unsigned T_WR_NS    = 55,
  parameter int unsigned T_FLOAT_NS = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  localparam int unsigned RD_CYC   = ns_to_cycles(T_RD_NS, CLK_PS);
  localparam int unsigned WR_CYC   = ns_to_cycles(T_WR_NS, CLK_PS);
  localparam int unsigned TURN_CYC = ns_to_cycles(T_FLOAT_NS, CLK_PS);
  localparam int unsigned CNT_W    = count_bits(max3(RD_CYC, WR_CYC, TURN_CYC));
  localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LOAD   = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LOAD = CNT_W'(TURN_CYC);

  // Named internal events, also watched by the bound checker.
  seq_state_e state_q, state_d;
  logic accept, rd_done, pulse_start;
  logic phase_hit, gap_clear;
  logic phase_load;
  logic [CNT_W-1:0] phase_val;

  assign phase_load = (accept && !req_write) || pulse_start;
  assign phase_val  = pulse_start ? WR_LOAD : RD_LOAD;

  sram_cycle_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .req_write   (req_write),
    .phase_hit   (phase_hit),
    .gap_clear   (gap_clear),
    .state_q     (state_q),
    .state_d     (state_d),
    .accept      (accept),
    .rd_done     (rd_done),
    .pulse_start (pulse_start)
  );

  // Phase timer: length of the output-enable window or the write pulse.
  sram_interval_timer #(.W(CNT_W), .THRESH(0)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (phase_load),
    .load_val (phase_val),
    .hit      (phase_hit)
  );

  // Turnaround timer: armed when a load ends, clear one edge before expiry.
  sram_interval_timer #(.W(CNT_W), .THRESH(1)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (rd_done),
    .load_val (TURN_LOAD),
    .hit      (gap_clear)
  );

  assign ready = (state_q == ST_IDLE);

  // Host-side request registers, held for the whole memory cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  // Memory strobes registered from the next state, so the pins never glitch.
  logic sel_d;
  assign sel_d = (state_d != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_ce_n  <= 1'b1;
      mem_ce2   <= 1'b0;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      mem_ce_n  <= !sel_d;
      mem_ce2   <= sel_d;
      mem_oe_n  <= (state_d != ST_RD);
      mem_we_n  <= (state_d != ST_WPULSE);
      mem_dq_oe <= (state_d == ST_WPULSE) || (state_d == ST_WEND);
    end
  end

  // Load result capture on the last counted edge of the access window.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_done;
      if (rd_done) rd_data <= mem_dq_in;
    end
  end

endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
  parameter int unsigned ADDR_W   = 17,
  parameter int unsigned RD_CYC   = 14,
  parameter int unsigned WR_CYC   = 14,
  parameter int unsigned TURN_CYC = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              rd_valid,
  input logic              mem_ce_n,
  input logic              mem_ce2,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              accept,
  input logic              rd_done
);

  logic [15:0] we_low_cnt, oe_low_cnt, since_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_low_cnt <= '0;
      oe_low_cnt <= '0;
      since_rd   <= 16'hFFFF;
    end else begin
      we_low_cnt <= !mem_we_n ? we_low_cnt + 16'd1 : 16'd0;
      oe_low_cnt <= !mem_oe_n ? oe_low_cnt + 16'd1 : 16'd0;
      if (!mem_oe_n)                since_rd <= '0;
      else if (since_rd != 16'hFFFF) since_rd <= since_rd + 16'd1;
    end
  end

  a_r2_strobe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || !mem_oe_n) |-> (!mem_ce_n && mem_ce2));

  a_r3_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  a_r4_oe_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_low_cnt == 16'(RD_CYC)));

  a_r4_valid_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> rd_valid);

  a_r4_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  a_r5_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_cnt == 16'(WR_CYC)));

  a_r6_end_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_ce_n && mem_ce2 && mem_dq_oe));

  a_r6_release_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_dq_oe) |-> ($past(mem_we_n) && mem_we_n));

  a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  a_r8_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (since_rd >= 16'(TURN_CYC)));

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);

  a_r9_selected_means_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !ready);

endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .RD_CYC   (RD_CYC),
  .WR_CYC   (WR_CYC),
  .TURN_CYC (TURN_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ready     (ready),
  .rd_valid  (rd_valid),
  .mem_ce_n  (mem_ce_n),
  .mem_ce2   (mem_ce2),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_oe (mem_dq_oe),
  .mem_addr  (mem_addr),
  .accept    (accept),
  .rd_done   (rd_done)
);

// File: tb/sram_cycle_ctrl_test.sv
`timescale 1ns/1ps
module sram_cycle_ctrl_test;

  localparam int AW = 17;
  localparam int DW = 8;

  // R10: bench's own ceiling by counting clock periods.
  function automatic int bench_cycles(input int ns, input int ps);
    int n = 0;
    while (n * ps < ns * 1000) n++;
    return (n < 1) ? 1 : n;
  endfunction

  localparam int EXP_RD   = bench_cycles(55, 4000);
  localparam int EXP_WR   = bench_cycles(55, 4000);
  localparam int EXP_TURN = bench_cycles(30, 4000);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic ready, rd_valid;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] mem_addr;
  logic mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in = 8'h5A;

  always #2 clk = ~clk;

  sram_cycle_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
    .mem_dq_oe(mem_dq_oe)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] power_up_byte(input logic [AW-1:0] a);
    return DW'(a * 7 + 3);
  endfunction

  // Memory model (fed by the pins) and reference (fed by the host requests).
  logic [DW-1:0] model_mem [int];
  logic [DW-1:0] ref_mem [int];

  function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
    return model_mem.exists(int'(a)) ? model_mem[int'(a)] : power_up_byte(a);
  endfunction

  function automatic logic [DW-1:0] ref_read(input logic [AW-1:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : power_up_byte(a);
  endfunction

  logic [AW-1:0] cur_addr = '0;
  bit monitor_on = 1'b0;
  bit seen_read = 1'b0;
  int cyc = 0, we_run = 0, oe_run = 0, last_oe_rise = 0;
  logic prev_we_n = 1'b1, prev_oe_n = 1'b1, prev_dq_oe = 1'b0, prev_sel = 1'b0;
  logic [AW-1:0] prev_addr = '0;

  // Pin monitor and memory model, all on the falling edge.
  always @(negedge clk) begin
    if (monitor_on) begin
      logic sel;
      cyc++;
      sel = !mem_ce_n && mem_ce2;
      if (!mem_we_n || !mem_oe_n) check(sel, "R2 strobe without select", sel, 1);
      if (mem_dq_oe) check(mem_oe_n, "R3 bus contention", mem_oe_n, 1);
      if (!mem_we_n) begin
        we_run++;
        check(mem_dq_oe && mem_dq_out == ref_read(cur_addr), "R5 data during pulse",
              int'(mem_dq_out), int'(ref_read(cur_addr)));
      end
      if (!mem_oe_n) oe_run++;
      if (!prev_we_n && mem_we_n) begin
        check(we_run == EXP_WR, "R5 R10 write pulse length", we_run, EXP_WR);
        check(sel && mem_dq_oe, "R6 write ends selected and driven", {sel, mem_dq_oe}, 3);
        model_mem[int'(mem_addr)] = mem_dq_out;
        we_run = 0;
      end
      if (!prev_oe_n && mem_oe_n) begin
        check(oe_run == EXP_RD, "R4 R10 output enable window", oe_run, EXP_RD);
        oe_run = 0;
        last_oe_rise = cyc;
        seen_read = 1'b1;
      end
      if (!prev_dq_oe && mem_dq_oe && seen_read)
        check(cyc - last_oe_rise >= EXP_TURN, "R8 turnaround gap",
              cyc - last_oe_rise, EXP_TURN);
      if (prev_dq_oe && !mem_dq_oe)
        check(prev_we_n && mem_we_n, "R6 release after write end", {prev_we_n, mem_we_n}, 3);
      if (sel && prev_sel)
        check(mem_addr == prev_addr && mem_addr == cur_addr, "R7 address held",
              int'(mem_addr), int'(cur_addr));
      mem_dq_in = (sel && !mem_oe_n && mem_we_n) ? model_read(mem_addr) : 8'h5A;
      prev_we_n = mem_we_n; prev_oe_n = mem_oe_n; prev_dq_oe = mem_dq_oe;
      prev_sel = sel; prev_addr = mem_addr;
    end
  end

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    wait_ready();
    req = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    cur_addr = a;
    if (wr) ref_mem[int'(a)] = d;
    @(negedge clk);
    req = 1'b0;
    check(!ready, "R9 ready low after accept", ready, 0);
  endtask

  task automatic finish_read(input logic [AW-1:0] a, input int already);
    int n = already;
    logic [DW-1:0] exp = ref_read(a);
    while (!rd_valid) begin @(negedge clk); n++; end
    check(n == EXP_RD + 1, "R4 read latency", n, EXP_RD + 1);
    check(rd_data == exp, "R4 read data", int'(rd_data), int'(exp));
    @(negedge clk);
    check(!rd_valid, "R4 valid single cycle", rd_valid, 0);
  endtask

  task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    issue(wr, a, d);
    if (!wr) finish_read(a, 1);
    else wait_ready();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    check(ready && !rd_valid && mem_ce_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe,
          "R1 outputs in reset", {ready, rd_valid, mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe},
          7'b1010110);
    rst_n = 1'b1;
    monitor_on = 1'b1;
    repeat (3) @(negedge clk);
    check(ready && !rd_valid && mem_ce_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe,
          "R1 idle after reset", {ready, rd_valid, mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe},
          7'b1010110);
    check(EXP_RD == 14 && EXP_TURN == 8, "R10 derived counts", EXP_RD * 100 + EXP_TURN, 1408);

    // Boundary addresses (R7), write then read back.
    do_op(1'b1, 17'h00000, 8'h00);
    do_op(1'b1, 17'h1FFFF, 8'hFF);
    do_op(1'b0, 17'h00000, 8'h00);
    do_op(1'b0, 17'h1FFFF, 8'h00);
    // Unwritten word.
    do_op(1'b0, 17'h0ABCD, 8'h00);
    // Store immediately after a load: turnaround (R8).
    do_op(1'b0, 17'h00010, 8'h00);
    do_op(1'b1, 17'h00011, 8'hC3);
    do_op(1'b0, 17'h00011, 8'h00);

    // R9: requests while busy are ignored.
    issue(1'b0, 17'h00020, 8'h00);
    repeat (4) begin
      req = 1'b1; req_write = 1'b1; req_addr = 17'h00021; req_wdata = 8'hEE;
      @(negedge clk);
      check(!ready, "R9 still busy", ready, 0);
    end
    req = 1'b0;
    finish_read(17'h00020, 5);
    do_op(1'b0, 17'h00021, 8'h00);

    // Random traffic.
    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] a;
      bit wr;
      a  = ($urandom % 4 == 0) ? AW'($urandom) : AW'($urandom % 64);
      wr = ($urandom % 2) == 1;
      do_op(wr, a, DW'($urandom));
    end

    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule